// File: doc/BRIEF.md
# Page Write Buffer with Self-Timed Commit

This block gathers the data bytes of one memory write transaction into a page-sized staging buffer and then commits them to a byte-wide storage array in a self-timed write cycle. A bus front end marks the start of a transaction by presenting the starting word address. It then hands over each received data byte with a one-cycle strobe, and raises a commit strobe when the bus transaction closes. It can instead raise an abort strobe when writes are blocked by hardware protection.

The word address is split into a row (page) part and a column part. Each buffered byte lands at the current column, and the column then advances, wrapping inside the page. The row never moves, so a transfer longer than a page overwrites bytes that are already staged. A per-byte valid mask records which columns were loaded, so a partial page updates only those locations. On commit the block raises busy for a programmable number of clock cycles. In the first page-size cycles of that window it walks the columns in ascending order and drives one array write for each loaded column. While busy is high the block ignores all transaction inputs. The page size (8 or 16 bytes for the usual densities), the address width and the write-cycle length are parameters.

Top module: `pageWriteBuffer`

## Requirements
- R1: After reset, busy and memWe are 0 and addrOut is 0.
- R2: A startValid pulse while idle loads startAddr into the address counter; addrOut equals startAddr in the next cycle. The low log2(PAGE_BYTES) bits form the column and the remaining upper bits form the row.
- R3: Each byteValid pulse while idle stores byteData at the current column and advances the column by one, wrapping from PAGE_BYTES-1 to 0. The row bits of addrOut never change except on startValid.
- R4: During a commit, exactly the loaded columns are written, in ascending column order, at address {row, column}. Each write carries the last byte staged at that column. No write occurs outside busy.
- R5: A commit pulse while idle, with at least one byte loaded, raises busy in the next cycle. Busy then stays high for exactly WRITE_CYCLES cycles.
- R6: While busy, startValid, byteValid, commit and protectAbort are ignored: addrOut does not change and no extra array write occurs.
- R7: A commit pulse with no loaded bytes leaves busy low and produces no array write.
- R8: A protectAbort pulse while idle discards all staged bytes, so a following commit writes nothing.
- R9: The valid mask is cleared when a write cycle ends, so a second commit with no new bytes writes nothing.
- R10: After a write cycle, addrOut points one column past the last byte received, wrapped within the same row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Transaction start; loads startAddr |
| startAddr | input | ADDR_W | Starting word address |
| byteValid | input | 1 | One data byte is present |
| byteData | input | 8 | Data byte to stage |
| commit | input | 1 | Begin the self-timed write cycle |
| protectAbort | input | 1 | Discard staged bytes (write protected) |
| busy | output | 1 | Write cycle in progress |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memData | output | 8 | Array write data |
| addrOut | output | ADDR_W | Current word address counter |

## Verification
All inputs are registered on the rising edge. A start or a byte therefore shows on addrOut at the next falling edge, and a commit shows busy at the next falling edge. Column c of the page is written in the (c+1)-th busy cycle, since the walk starts in the first busy cycle. The bench drives on falling edges and samples one falling edge after each stimulus. Each commit pushes its expected writes onto a queue, and a monitor pops one entry on every falling edge that shows memWe high. The same monitor measures every busy run at its falling edge and compares it with WRITE_CYCLES.

// File: rtl/pw_pkg.sv
package pw_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic loadByte;
    logic clearMask;
    logic scanActive;
  } pwStrobes_t;
endpackage

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
#(
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 40,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             byteValid,
  input  logic             commit,
  input  logic             protectAbort,
  input  logic             maskAny,
  output pwStrobes_t       strobes,
  output logic [COL_W-1:0] scanIdx,
  output logic             busy
);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SCAN_SPAN = CNT_W'(PAGE_BYTES);

  logic [CNT_W-1:0] cnt;
  logic             goWrite;
  logic             lastCycle;

  assign lastCycle = busy && (cnt == LAST_CNT);
  assign goWrite   = !busy && commit && !protectAbort && !startValid && maskAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (lastCycle) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (goWrite) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  always_comb begin
    strobes.loadStart  = !busy && startValid;
    strobes.loadByte   = !busy && byteValid && !startValid;
    strobes.clearMask  = (!busy && (startValid || protectAbort)) || lastCycle;
    strobes.scanActive = busy && (cnt < SCAN_SPAN);
  end

  assign scanIdx = cnt[COL_W-1:0];
endmodule

// File: rtl/pw_datapath.sv
module pw_datapath
  import pw_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwStrobes_t        strobes,
  input  logic [COL_W-1:0]  scanIdx,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [7:0]        byteData,
  output logic              maskAny,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [ADDR_W-1:0] addrOut
);
  logic [ROW_W-1:0]      row;
  logic [COL_W-1:0]      col;
  logic [7:0]            laneData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] laneValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      row <= '0;
      col <= '0;
    end else if (strobes.loadStart) begin
      row <= startAddr[ADDR_W-1:COL_W];
      col <= startAddr[COL_W-1:0];
    end else if (strobes.loadByte) begin
      col <= col + 1'b1;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    logic hit;
    assign hit = strobes.loadByte && (col == COL_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneData[g]  <= '0;
        laneValid[g] <= 1'b0;
      end else begin
        if (hit) laneData[g] <= byteData;
        if (hit) laneValid[g] <= 1'b1;
        else if (strobes.clearMask) laneValid[g] <= 1'b0;
      end
    end
  end

  assign maskAny = |laneValid;
  assign memWe   = strobes.scanActive && laneValid[scanIdx];
  assign memAddr = {row, scanIdx};
  assign memData = laneData[scanIdx];
  assign addrOut = {row, col};
endmodule

// File: rtl/pageWriteBuffer.sv
module pageWriteBuffer
  import pw_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 40,
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              commit,
  input  logic              protectAbort,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [ADDR_W-1:0] addrOut
);
  pwStrobes_t       strobes;
  logic [COL_W-1:0] scanIdx;
  logic             maskAny;

  pw_ctrl #(.PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .byteValid(byteValid),
    .commit(commit), .protectAbort(protectAbort), .maskAny(maskAny),
    .strobes(strobes), .scanIdx(scanIdx), .busy(busy)
  );

  pw_datapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .scanIdx(scanIdx),
    .startAddr(startAddr), .byteData(byteData), .maskAny(maskAny),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .addrOut(addrOut)
  );
endmodule

// File: rtl/pageWriteBuffer_chk.sv
module pageWriteBuffer_chk #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 40,
  localparam int COL_W = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic              commit,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] addrOut
);
  int busyLen;
  always_ff @(posedge clk) begin
    if (!rstN)     busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else           busyLen <= 0;
  end

  assert_we_in_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  assert_busy_after_commit_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(commit));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == WRITE_CYCLES));

  assert_row_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> $stable(addrOut[ADDR_W-1:COL_W]));

  assert_frozen_while_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(addrOut));
endmodule

bind pageWriteBuffer pageWriteBuffer_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .commit(commit),
  .busy(busy), .memWe(memWe), .addrOut(addrOut)
);

// File: tb/pageWriteBuffer_tb.sv
module pageWriteBuffer_tb;
  localparam int AW = 11;
  localparam int PB = 16;
  localparam int WC = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startValid = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic          byteValid = 1'b0;
  logic [7:0]    byteData = '0;
  logic          commit = 1'b0;
  logic          protectAbort = 1'b0;
  logic          busy, memWe;
  logic [AW-1:0] memAddr, addrOut;
  logic [7:0]    memData;

  always #4 clk = ~clk;

  pageWriteBuffer #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .commit(commit),
    .protectAbort(protectAbort), .busy(busy), .memWe(memWe),
    .memAddr(memAddr), .memData(memData), .addrOut(addrOut)
  );

  int checks = 0;
  int errors = 0;

  // bench model
  logic [6:0]    expRow = '0;
  logic [3:0]    expCol = '0;
  logic [PB-1:0] expMask = '0;
  logic [7:0]    expBuf [PB];
  logic [AW+7:0] expQ [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: array writes and busy run length
  bit prevBusy = 1'b0;
  int runLen = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected write", int'({memAddr, memData}), 0);
        end else begin
          logic [AW+7:0] e;
          e = expQ.pop_front();
          check({memAddr, memData} == e, "R4 write addr/data",
                int'({memAddr, memData}), int'(e));
        end
      end
      if (busy) runLen++;
      if (prevBusy && !busy) begin
        check(runLen == WC, "R5 busy length", runLen, WC);
        runLen = 0;
      end
      prevBusy = busy;
    end
  end

  task automatic doStart(input logic [AW-1:0] a);
    @(negedge clk); startValid = 1'b1; startAddr = a;
    @(negedge clk); startValid = 1'b0;
    expRow = a[AW-1:4]; expCol = a[3:0]; expMask = '0;
    check(addrOut == a, "R2 start address", int'(addrOut), int'(a));
  endtask

  task automatic doByte(input logic [7:0] d);
    @(negedge clk); byteValid = 1'b1; byteData = d;
    @(negedge clk); byteValid = 1'b0;
    expBuf[expCol] = d; expMask[expCol] = 1'b1; expCol = expCol + 1'b1;
  endtask

  task automatic doAbort();
    @(negedge clk); protectAbort = 1'b1;
    @(negedge clk); protectAbort = 1'b0;
    expMask = '0;
  endtask

  task automatic doCommit(input bit waitDone);
    bit expBusy;
    expBusy = (expMask != '0);
    for (int c = 0; c < PB; c++)
      if (expMask[c]) expQ.push_back({expRow, 4'(c), expBuf[c]});
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    check(busy == expBusy, expBusy ? "R5 busy after commit" : "R7 no busy on empty commit",
          int'(busy), int'(expBusy));
    expMask = '0;
    if (waitDone) begin
      while (busy) @(negedge clk);
      @(negedge clk);
      check(addrOut == {expRow, expCol}, "R10 address after write",
            int'(addrOut), int'({expRow, expCol}));
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < PB; i++) expBuf[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && memWe == 1'b0, "R1 reset outputs", int'({busy, memWe}), 0);
    check(addrOut == '0, "R1 reset address", int'(addrOut), 0);

    // partial page
    doStart(11'h123);
    doByte(8'hA1); doByte(8'hA2); doByte(8'hA3);
    check(addrOut == 11'h126, "R3 column advance", int'(addrOut), 'h126);
    doCommit(1'b1);

    // wrap and overwrite: 20 bytes from column 14
    doStart(11'h07E);
    for (int i = 0; i < 20; i++) doByte(8'(8'h10 + i));
    check(addrOut == 11'h072, "R3 wrap keeps row", int'(addrOut), 'h072);
    doCommit(1'b1);

    // mask cleared after write
    doCommit(1'b1);                       // R9 expects no busy, no writes
    check(busy == 1'b0, "R9 idle after empty commit", int'(busy), 0);

    // commit with nothing loaded after a fresh start
    doStart(11'h040);
    doCommit(1'b0);                       // R7

    // abort discards staged bytes
    doStart(11'h200);
    doByte(8'h5A); doByte(8'h5B);
    doAbort();
    doCommit(1'b0);                       // R8 expects no busy
    check(busy == 1'b0, "R8 abort discards", int'(busy), 0);

    // single byte at last column, inputs ignored while busy
    doStart(11'h7FF);
    doByte(8'hC3);
    check(addrOut == 11'h7F0, "R10 wrap of counter", int'(addrOut), 'h7F0);
    doCommit(1'b0);
    @(negedge clk); startValid = 1'b1; startAddr = 11'h001;
    @(negedge clk); startValid = 1'b0; byteValid = 1'b1; byteData = 8'hEE;
    @(negedge clk); byteValid = 1'b0; commit = 1'b1; protectAbort = 1'b1;
    @(negedge clk); commit = 1'b0; protectAbort = 1'b0;
    check(addrOut == 11'h7F0, "R6 address frozen while busy", int'(addrOut), 'h7F0);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(addrOut == 11'h7F0, "R6 address after busy", int'(addrOut), 'h7F0);
    doCommit(1'b1);                       // R6 byte during busy must not be staged

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R4 all expected writes seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule